// File: doc/BRIEF.md
# Golomb Run Bit Generator

This block turns a compressed byte stream in ROM into binary decisions for eight independent code orders, numbered 0 to 7. A caller pulses `start` with a byte address and then asks for bits one at a time. Each request names a code order and gets back one bit and an end-of-run flag. The four high bits of the first byte form a header. The block skips them and begins decoding at bit 4 of that byte. Bits are taken from each byte most significant bit first.

Every order keeps its own pending run: a count of zero (most-probable) bits, plus a flag that says a single one (least-probable) bit follows that count. While an order still holds a pending run, its request is answered from that run without touching ROM. An order that has used up its run pulls a fresh codeword from the bit position shared by all eight orders. That codeword may take one ROM read or two. The ROM port is single-ported and returns data one cycle after `rom_rd`.

Top module: `golomb_run_gen`

## Requirements
- R1: After reset `bit_valid` and `rom_rd` are low and `req_ready` is high.
- R2: After `start`, decoding begins at bit 4 of the byte at `start_addr`, counting bit 0 as the most significant bit. The upper nibble of that byte is never decoded.
- R3: A codeword whose first bit is 0, fetched for order n, consumes 1 bit. It yields 2^n zero bits, and `bit_end` is 1 only on the last of them.
- R4: A codeword whose first bit is 1, fetched for order n, consumes n+1 bits. It yields k zero bits and then a single one bit, which always carries `bit_end`=1. The value k is the n bits after the leading 1, read in reverse order (the first stream bit is the least significant bit of k) and then inverted.
- R5: An order fetches a codeword only when its zero count is 0 and its one-pending flag is clear. Otherwise the answer comes with no ROM read. A request for one order never changes the pending run of another order.
- R6: The bit position advances by the bits a codeword consumes and carries into the next byte address. A codeword that crosses a byte boundary is read with two ROM reads, at the current address and then the next one.
- R7: `start` discards the pending run of every order. The next request for any order fetches a new codeword from the new stream.
- R8: A request is taken only in a cycle where `req_ready` is high. Each request taken gives exactly one `bit_valid` pulse. `req_ready` is low while a codeword fetch is in progress.
- R9: `rom_rd` is never high in two consecutive cycles. The data from a read is used in the cycle after `rom_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new stream; clears all runs |
| start_addr | input | ADDR_W | Byte address of the stream header |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_data | input | 8 | ROM data, valid one cycle after `rom_rd` |
| req | input | 1 | Bit request |
| req_order | input | 3 | Code order of the request |
| req_ready | output | 1 | Request can be taken this cycle |
| bit_valid | output | 1 | Result pulse |
| bit_out | output | 1 | Decoded bit |
| bit_end | output | 1 | This bit closes the run of its order |

## Verification
The assertions assume that the ROM returns the addressed byte exactly one cycle after `rom_rd`. They also assume that `req` is raised only while `req_ready` is high and that `start` is never raised in the same cycle as a request. The bench's ROM model is a register loaded on `rom_rd`. The bench drives `req` and `start` on the falling edge, raises `req` only after it has seen `req_ready` high, and issues `start` only between requests. Expected bits come from a bench model that reads the stream bit by bit at absolute positions.

// File: rtl/grg_pkg.sv
package grg_pkg;
  localparam int ORD_N = 8;
  localparam int ORD_W = $clog2(ORD_N);
  localparam int CNT_W = ORD_N;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [ORD_W-1:0] ord_t;

  typedef struct packed {
    cnt_t mps;
    logic lps;
  } run_t;

  typedef struct packed {
    run_t nxt;
    logic ob;
    logic last;
  } step_t;

  // eight stream bits starting at position p of byte hi, continuing into lo
  function automatic logic [7:0] win_at(logic [7:0] hi, logic [7:0] lo, logic [2:0] p);
    logic [15:0] w;
    w = {hi, lo} << p;
    return w[15:8];
  endfunction

  // bits a codeword of order n consumes given its leading bit
  function automatic logic [3:0] bits_used(logic lead, ord_t n);
    return lead ? (4'(n) + 4'd1) : 4'd1;
  endfunction

  // run described by a codeword window of order n
  function automatic run_t run_decode(logic [7:0] win, ord_t n);
    run_t r;
    r.mps = '0;
    r.lps = win[7];
    if (!win[7]) begin
      r.mps = cnt_t'(1) << n;
    end else begin
      for (int i = 0; i < ORD_N - 1; i++) begin
        if (i < int'(n)) r.mps[i] = ~win[6-i];
      end
    end
    return r;
  endfunction

  // emit one bit from a live run
  function automatic step_t run_step(run_t cur);
    step_t s;
    if (cur.mps != '0) begin
      s.nxt.mps = cur.mps - cnt_t'(1);
      s.nxt.lps = cur.lps;
      s.ob      = 1'b0;
    end else begin
      s.nxt.mps = '0;
      s.nxt.lps = 1'b0;
      s.ob      = 1'b1;
    end
    s.last = (s.nxt.mps == '0) && !s.nxt.lps;
    return s;
  endfunction
endpackage

// File: rtl/grg_reader.sv
module grg_reader
  import grg_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              go,
  input  ord_t              ord,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic              done,
  output run_t              run
);
  typedef enum logic [2:0] {R_IDLE, R_F0, R_L0, R_F1, R_L1} rst_e;

  localparam logic [2:0] HDR_SKIP = 3'd4;

  rst_e              st;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        ptr;
  logic [7:0]        b0;

  logic [7:0] win0, win;
  logic       need2;
  logic [3:0] adv;

  assign rom_rd   = (st == R_F0) || (st == R_F1);
  assign rom_addr = (st == R_F1) ? addr + ADDR_W'(1) : addr;

  assign win0  = win_at(rom_data, 8'h00, ptr);
  assign need2 = (st == R_L0) && win0[7] && (({1'b0, ptr} + bits_used(1'b1, ord)) > 4'd8);
  assign win   = (st == R_L1) ? win_at(b0, rom_data, ptr) : win0;
  assign done  = ((st == R_L0) && !need2) || (st == R_L1);
  assign run   = run_decode(win, ord);
  assign adv   = {1'b0, ptr} + bits_used(win[7], ord);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= R_IDLE;
      addr <= '0;
      ptr  <= HDR_SKIP;
      b0   <= '0;
    end else if (start) begin
      st   <= R_IDLE;
      addr <= start_addr;
      ptr  <= HDR_SKIP;
    end else begin
      case (st)
        R_IDLE: if (go) st <= R_F0;
        R_F0:   st <= R_L0;
        R_L0: begin
          if (need2) begin
            b0 <= rom_data;
            st <= R_F1;
          end else begin
            addr <= addr + ADDR_W'(adv[3]);
            ptr  <= adv[2:0];
            st   <= R_IDLE;
          end
        end
        R_F1:   st <= R_L1;
        R_L1: begin
          addr <= addr + ADDR_W'(adv[3]);
          ptr  <= adv[2:0];
          st   <= R_IDLE;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // R9
  rom_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> !rom_rd);

  // R9
  data_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rom_rd));
endmodule

// File: rtl/grg_slot.sv
module grg_slot
  import grg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic we,
  input  run_t d,
  output run_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (we)  q <= d;
  end

  // R7
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q.mps == '0) && !q.lps);
endmodule

// File: rtl/golomb_run_gen.sv
module golomb_run_gen
  import grg_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  input  logic              req,
  input  logic [2:0]        req_order,
  output logic              req_ready,
  output logic              bit_valid,
  output logic              bit_out,
  output logic              bit_end
);
  typedef enum logic {T_IDLE, T_WAIT} tst_e;

  tst_e  ts;
  ord_t  sel;
  run_t  slot_q [ORD_N];

  logic  accept, live, rd_go, rd_done, wr;
  ord_t  wr_sel;
  run_t  cur, rd_run;
  step_t st_live, st_new, st_use;

  assign req_ready = (ts == T_IDLE) && !start;
  assign accept    = req && req_ready;
  assign cur       = slot_q[req_order];
  assign live      = (cur.mps != '0) || cur.lps;
  assign rd_go     = accept && !live;
  assign st_live   = run_step(cur);
  assign st_new    = run_step(rd_run);
  assign wr        = (accept && live) || ((ts == T_WAIT) && rd_done && !start);
  assign wr_sel    = accept ? req_order : sel;
  assign st_use    = accept ? st_live : st_new;

  grg_reader #(.ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .go         (rd_go),
    .ord        (accept ? req_order : sel),
    .rom_rd     (rom_rd),
    .rom_addr   (rom_addr),
    .rom_data   (rom_data),
    .done       (rd_done),
    .run        (rd_run)
  );

  for (genvar gi = 0; gi < ORD_N; gi++) begin : g_slot
    grg_slot u_s (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .we    (wr && (wr_sel == ord_t'(gi))),
      .d     (st_use.nxt),
      .q     (slot_q[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts        <= T_IDLE;
      sel       <= '0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
      bit_end   <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (start) begin
        ts <= T_IDLE;
      end else if (accept) begin
        sel <= req_order;
        if (live) begin
          bit_valid <= 1'b1;
          bit_out   <= st_live.ob;
          bit_end   <= st_live.last;
        end else begin
          ts <= T_WAIT;
        end
      end else if ((ts == T_WAIT) && rd_done) begin
        bit_valid <= 1'b1;
        bit_out   <= st_new.ob;
        bit_end   <= st_new.last;
        ts        <= T_IDLE;
      end
    end
  end

  // R4
  lps_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_out) |-> bit_end);

  // R7
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !bit_valid);

  // R8
  fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !start) |=> (!req_ready || start));
endmodule

// File: tb/sim_golomb_run_gen.sv
module sim_golomb_run_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          rom_rd;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_q = '0;
  logic          req = 1'b0;
  logic [2:0]    req_order = '0;
  logic          req_ready, bit_valid, bit_out, bit_end;

  logic [7:0] mem [0:1023];
  int  checks = 0;
  int  failures = 0;
  int  rpos;
  int  rmps [8];
  bit  rlps [8];
  int  rd_pairs = 0;
  logic prev_rd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  golomb_run_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_q),
    .req(req), .req_order(req_order), .req_ready(req_ready),
    .bit_valid(bit_valid), .bit_out(bit_out), .bit_end(bit_end)
  );

  always_ff @(posedge clk) if (rom_rd) rom_q <= mem[rom_addr[9:0]];

  always @(negedge clk) begin
    if (prev_rd && rom_rd) rd_pairs++;
    prev_rd <= rom_rd;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sbit(int pos);
    return int'(mem[pos >> 3][7 - (pos & 7)]);
  endfunction

  task automatic ref_next(int n, output int b, output int e);
    if (rmps[n] == 0 && !rlps[n]) begin
      if (sbit(rpos) == 0) begin
        rmps[n] = 1 << n;
        rpos += 1;
      end else begin
        int k = 0;
        for (int i = 0; i < n; i++) if (sbit(rpos + 1 + i) == 0) k |= (1 << i);
        rmps[n] = k;
        rlps[n] = 1'b1;
        rpos += n + 1;
      end
    end
    if (rmps[n] != 0) begin b = 0; rmps[n]--; end
    else begin b = 1; rlps[n] = 1'b0; end
    e = (rmps[n] == 0 && !rlps[n]) ? 1 : 0;
  endtask

  task automatic start_at(int a);
    @(negedge clk);
    start = 1'b1;
    start_addr = AW'(a);
    @(negedge clk);
    start = 1'b0;
    rpos = a * 8 + 4;
    for (int i = 0; i < 8; i++) begin rmps[i] = 0; rlps[i] = 1'b0; end
  endtask

  task automatic req_bit(int n, output int b, output int e, output int rds);
    int t = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req = 1'b1;
    req_order = 3'(n);
    @(negedge clk);
    req = 1'b0;
    rds = 0;
    while (!bit_valid && t < 50) begin
      if (rom_rd) rds++;
      @(negedge clk);
      t++;
    end
    if (t >= 50) check("R8 response timeout", 0, 1);
    b = int'(bit_out);
    e = int'(bit_end);
  endtask

  task automatic t_reset;
    check("R1 bit_valid at reset", int'(bit_valid), 0);
    check("R1 rom_rd at reset", int'(rom_rd), 0);
    check("R1 req_ready at reset", int'(req_ready), 1);
  endtask

  task automatic t_plain_run;
    int b, e, r;
    mem[0] = 8'hA0;
    start_at(0);
    for (int i = 0; i < 8; i++) begin
      req_bit(3, b, e, r);
      check("R3 zero bit of order-3 run", b, 0);
      check("R3 end only on eighth bit", e, (i == 7) ? 1 : 0);
      if (i == 0) check("R2 header skipped, one read", r, 1);
    end
  endtask

  task automatic t_lps_run;
    int b, e, r;
    mem[8] = 8'h0B;
    mem[9] = 8'hA0;
    start_at(8);
    req_bit(2, b, e, r);
    check("R4 order2 first bit", b, 0); check("R4 order2 first end", e, 0);
    check("R2 single read", r, 1);
    req_bit(2, b, e, r);
    check("R4 order2 one bit", b, 1); check("R4 order2 one end", e, 1);
    req_bit(3, b, e, r);
    check("R6 straddle reads", r, 2);
    check("R4 order3 bit0", b, 0); check("R4 order3 end0", e, 0);
    req_bit(3, b, e, r);
    check("R4 order3 bit1", b, 0); check("R4 order3 end1", e, 0);
    req_bit(3, b, e, r);
    check("R4 order3 bit2", b, 1); check("R4 order3 end2", e, 1);
    req_bit(0, b, e, r);
    check("R6 next byte addressed", r, 1);
    check("R3 order0 bit", b, 0); check("R3 order0 end", e, 1);
  endtask

  task automatic t_live_no_fetch;
    int b, e, r;
    mem[16] = 8'h00;
    mem[17] = 8'h00;
    start_at(16);
    req_bit(2, b, e, r);
    check("R5 first fetch reads", r, 1);
    req_bit(5, b, e, r);
    check("R5 other order fetches", r, 1);
    req_bit(2, b, e, r);
    check("R5 live order no read", r, 0);
    check("R5 order2 bit kept", b, 0); check("R5 order2 end kept", e, 0);
    req_bit(2, b, e, r);
    req_bit(2, b, e, r);
    check("R5 order2 last no read", r, 0);
    check("R5 order2 run closes", e, 1);
  endtask

  task automatic t_restart;
    int b, e, r;
    mem[24] = 8'h00;
    mem[32] = 8'h0F;
    mem[33] = 8'hFF;
    start_at(24);
    req_bit(4, b, e, r);
    check("R7 pre-restart run", e, 0);
    start_at(32);
    req_bit(4, b, e, r);
    check("R7 fetch after restart", r, 2);
    check("R7 new stream bit", b, 1);
    check("R7 new stream end", e, 1);
  endtask

  task automatic t_handshake;
    int t = 0;
    mem[40] = 8'h00;
    start_at(40);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req = 1'b1;
    req_order = 3'd1;
    @(negedge clk);
    req = 1'b0;
    check("R8 not ready during fetch", int'(req_ready), 0);
    while (!bit_valid && t < 50) begin @(negedge clk); t++; end
    check("R8 valid seen", int'(bit_valid), 1);
    @(negedge clk);
    check("R8 single valid pulse", int'(bit_valid), 0);
  endtask

  task automatic t_stream;
    logic [15:0] lf = 16'hACE1;
    int b, e, r, eb, ee, errs = 0;
    for (int i = 64; i < 1024; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem[i] = lf[7:0];
    end
    start_at(64);
    for (int i = 0; i < 400; i++) begin
      int n;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      n = int'(lf[2:0]);
      req_bit(n, b, e, r);
      ref_next(n, eb, ee);
      if (b != eb || e != ee) begin
        errs++;
        check("R5 R4 R3 R6 stream bit", b, eb);
        check("R5 R4 R3 R6 stream end", e, ee);
      end
    end
    check("R6 stream mismatches", errs, 0);
    check("R9 back-to-back reads", rd_pairs, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_plain_run();
    t_lps_run();
    t_live_no_fetch();
    t_restart();
    t_handshake();
    t_stream();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule